// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Checker

This unit keeps the single load-reserved reservation of one hart and settles the outcome of each store-conditional (SC). A load-reserved (LR) event records the 8-byte granule it touched, together with the identifier of the store that supplied its value. Writes made by other agents arrive on a snoop input. A snooped write that overlaps the granule destroys the reservation, unless it carries the recorded supplier identifier, because that write is the supplying store itself reaching memory.

An SC takes one of three paths. On the early-failure path it fails one cycle after the request and does no store work. On the late-failure path it fails two cycles after the request, once its address and data have been captured but before anything is committed. On the success path the unit returns the pass code and drives the memory write in the same cycle. No state exists in which the store is committed but not yet written. The unit decides success from the reservation as it stands in the decision cycle, so a snoop that arrives in that cycle still causes failure. Every SC clears the reservation, whichever path it takes.

The requester holds off a new SC until the response to the previous one has been returned.

Top module: `lrsc_resv_unit`

## Requirements
- R1: After reset no reservation is held. `sc_resp_valid` and `mem_wr_valid` are low, and an SC made with no prior LR fails.
- R2: The SC succeeds (`sc_resp_fail`=0) when it follows an LR to the same granule with no SC and no killing snoop in between. The response arrives two cycles after the request cycle. In that same cycle `mem_wr_valid` pulses for one cycle, carrying the SC address and data.
- R3: The reservation granule is the address with bits [2:0] ignored. An SC to any byte of the reserved granule can succeed. An SC to a different granule fails.
- R4: A snoop covers the naturally aligned block of 2^`snp_size` bytes (`snp_size` 0..6) that contains `snp_addr`. If that block overlaps the reserved granule and `snp_id` differs from the recorded source, the reservation is cleared. A snoop that does not overlap the granule has no effect.
- R5: An overlapping snoop whose `snp_id` equals the source identifier recorded by the LR leaves the reservation intact.
- R6: With `sc_fail_early`=1 on the request, the response arrives in the next cycle with `sc_resp_fail`=1, and no memory write occurs.
- R7: With `sc_fail_late`=1 and `sc_fail_early`=0, the response arrives two cycles after the request with `sc_resp_fail`=1, and no memory write occurs.
- R8: Every SC clears the reservation, so a second SC with no new LR in between fails.
- R9: A killing snoop presented in the cycle after the SC request (the decision cycle) makes that SC fail.
- R10: `mem_wr_valid` is high only together with `sc_resp_valid`=1 and `sc_resp_fail`=0.
- R11: A new LR replaces the reservation. An LR in the same cycle as a killing snoop sets the new reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_valid | input | 1 | LR event strobe |
| lr_addr | input | ADDR_W | LR byte address |
| lr_src_id | input | ID_W | Identifier of the store that supplied the LR value |
| snp_valid | input | 1 | External write snoop strobe |
| snp_addr | input | ADDR_W | Snooped write address |
| snp_size | input | SZ_W | log2 of the snooped write size in bytes |
| snp_id | input | ID_W | Identifier of the snooped store |
| sc_valid | input | 1 | SC request strobe |
| sc_addr | input | ADDR_W | SC byte address |
| sc_data | input | DATA_W | SC store data |
| sc_fail_early | input | 1 | Forces the early-failure path |
| sc_fail_late | input | 1 | Forces the late-failure path |
| sc_resp_valid | output | 1 | SC response strobe |
| sc_resp_fail | output | 1 | 0 on success, 1 on failure |
| mem_wr_valid | output | 1 | Memory write strobe (successful SC) |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |

## Verification
The bench aims at the races around the decision cycle:
- **Snoop during the decision cycle.** A checker that looks only at the registered reservation state would let this SC succeed.
- **Snoop with the recorded source identifier.** A design that ignores the identifier would fail an SC that should succeed.
- **Large and small snoop blocks, overlapping or adjacent to the granule.** Wrong mask arithmetic either kills reservations it should not touch or misses real overwrites.
- **Two SCs in a row.** If the reservation is not cleared after the first, the second wrongly succeeds.
- **Forced early and late failures.** An atomicity bug would show up as a memory write or response timing that does not match the forced path.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
   typedef enum logic [0:0] {
      SC_IDLE   = 1'b0,
      SC_DECIDE = 1'b1
   } sc_state_e;
endpackage

// File: rtl/lrsc_resv_track.sv
module lrsc_resv_track #(
   parameter int ADDR_W     = 32,
   parameter int ID_W       = 4,
   parameter int GRAN_LG    = 3,
   parameter int SNP_LG_MAX = 6,
   parameter int SZ_W       = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       lr_valid,
   input  logic [ADDR_W-1:0]          lr_addr,
   input  logic [ID_W-1:0]            lr_src_id,
   input  logic                       snp_valid,
   input  logic [ADDR_W-1:0]          snp_addr,
   input  logic [SZ_W-1:0]            snp_size,
   input  logic [ID_W-1:0]            snp_id,
   input  logic                       sc_done,
   output logic                       resv_valid,
   output logic [ADDR_W-GRAN_LG-1:0]  resv_gran,
   output logic                       snoop_kill
);
   localparam int GW = ADDR_W - GRAN_LG;

   logic [ID_W-1:0] resv_src;
   logic [GW-1:0]   snp_gran;
   logic [GW-1:0]   cmp_mask;
   logic            overlap;

   assign snp_gran = snp_addr[ADDR_W-1:GRAN_LG];

   generate
      if (SNP_LG_MAX <= GRAN_LG) begin : g_fixed
         // every snoop fits inside one granule
         assign cmp_mask = '1;
      end else begin : g_sized
         always_comb begin
            for (int i = 0; i < GW; i++) begin
               cmp_mask[i] = ((i + GRAN_LG) >= int'(snp_size));
            end
         end
      end
   endgenerate

   assign overlap    = ((snp_gran ^ resv_gran) & cmp_mask) == '0;
   assign snoop_kill = snp_valid && resv_valid && overlap && (snp_id != resv_src);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resv_valid <= 1'b0;
         resv_gran  <= '0;
         resv_src   <= '0;
      end else if (lr_valid) begin
         resv_valid <= 1'b1;
         resv_gran  <= lr_addr[ADDR_W-1:GRAN_LG];
         resv_src   <= lr_src_id;
      end else if (sc_done || snoop_kill) begin
         resv_valid <= 1'b0;
      end
   end

   // R4
   kill_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (snoop_kill && !lr_valid) |=> !resv_valid);
   // R11
   lr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lr_valid |=> resv_valid);
endmodule

// File: rtl/lrsc_sc_ctrl.sv
module lrsc_sc_ctrl
   import lrsc_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 64,
   parameter int GRAN_LG = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       sc_valid,
   input  logic [ADDR_W-1:0]          sc_addr,
   input  logic [DATA_W-1:0]          sc_data,
   input  logic                       sc_fail_early,
   input  logic                       sc_fail_late,
   input  logic                       resv_valid,
   input  logic [ADDR_W-GRAN_LG-1:0]  resv_gran,
   input  logic                       snoop_kill,
   output logic                       sc_done,
   output logic                       sc_resp_valid,
   output logic                       sc_resp_fail,
   output logic                       mem_wr_valid,
   output logic [ADDR_W-1:0]          mem_wr_addr,
   output logic [DATA_W-1:0]          mem_wr_data
);
   sc_state_e         state;
   logic [ADDR_W-1:0] p_addr;
   logic [DATA_W-1:0] p_data;
   logic              p_late;
   logic              pass;

   assign pass = !p_late && resv_valid && !snoop_kill &&
                 (p_addr[ADDR_W-1:GRAN_LG] == resv_gran);
   assign sc_done = (state == SC_DECIDE) ||
                    (state == SC_IDLE && sc_valid && sc_fail_early);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state         <= SC_IDLE;
         p_addr        <= '0;
         p_data        <= '0;
         p_late        <= 1'b0;
         sc_resp_valid <= 1'b0;
         sc_resp_fail  <= 1'b0;
         mem_wr_valid  <= 1'b0;
         mem_wr_addr   <= '0;
         mem_wr_data   <= '0;
      end else begin
         sc_resp_valid <= 1'b0;
         mem_wr_valid  <= 1'b0;
         case (state)
            SC_IDLE: begin
               if (sc_valid) begin
                  if (sc_fail_early) begin
                     sc_resp_valid <= 1'b1;
                     sc_resp_fail  <= 1'b1;
                  end else begin
                     state  <= SC_DECIDE;
                     p_addr <= sc_addr;
                     p_data <= sc_data;
                     p_late <= sc_fail_late;
                  end
               end
            end
            default: begin
               state         <= SC_IDLE;
               sc_resp_valid <= 1'b1;
               sc_resp_fail  <= !pass;
               mem_wr_valid  <= pass;
               mem_wr_addr   <= p_addr;
               mem_wr_data   <= p_data;
            end
         endcase
      end
   end

   // R10
   write_only_on_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> (sc_resp_valid && !sc_resp_fail));
   // R2
   pass_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_resp_valid && !sc_resp_fail) |-> mem_wr_valid);
   // R6
   early_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SC_IDLE && sc_valid && sc_fail_early) |=> (sc_resp_valid && sc_resp_fail && !mem_wr_valid));
   // R7
   late_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SC_DECIDE && p_late) |=> (sc_resp_valid && sc_resp_fail));
endmodule

// File: rtl/lrsc_resv_unit.sv
module lrsc_resv_unit #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 64,
   parameter int ID_W       = 4,
   parameter int GRAN_LG    = 3,
   parameter int SNP_LG_MAX = 6,
   parameter int SZ_W       = $clog2(SNP_LG_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lr_valid,
   input  logic [ADDR_W-1:0] lr_addr,
   input  logic [ID_W-1:0]   lr_src_id,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic [SZ_W-1:0]   snp_size,
   input  logic [ID_W-1:0]   snp_id,
   input  logic              sc_valid,
   input  logic [ADDR_W-1:0] sc_addr,
   input  logic [DATA_W-1:0] sc_data,
   input  logic              sc_fail_early,
   input  logic              sc_fail_late,
   output logic              sc_resp_valid,
   output logic              sc_resp_fail,
   output logic              mem_wr_valid,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [DATA_W-1:0] mem_wr_data
);
   localparam int GW = ADDR_W - GRAN_LG;

   initial begin
      if (GRAN_LG < 0 || GRAN_LG >= ADDR_W) $error("GRAN_LG out of range");
      if (SNP_LG_MAX >= ADDR_W) $error("SNP_LG_MAX too large");
      if ((1 << SZ_W) <= SNP_LG_MAX) $error("SZ_W too narrow");
      if (ID_W < 1 || DATA_W < 1) $error("bad width");
   end

   logic          resv_valid;
   logic [GW-1:0] resv_gran;
   logic          snoop_kill;
   logic          sc_done;

   lrsc_resv_track #(
      .ADDR_W(ADDR_W), .ID_W(ID_W), .GRAN_LG(GRAN_LG),
      .SNP_LG_MAX(SNP_LG_MAX), .SZ_W(SZ_W)
   ) u_track (
      .clk(clk), .rst_n(rst_n),
      .lr_valid(lr_valid), .lr_addr(lr_addr), .lr_src_id(lr_src_id),
      .snp_valid(snp_valid), .snp_addr(snp_addr), .snp_size(snp_size), .snp_id(snp_id),
      .sc_done(sc_done),
      .resv_valid(resv_valid), .resv_gran(resv_gran), .snoop_kill(snoop_kill)
   );

   lrsc_sc_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GRAN_LG(GRAN_LG)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_data(sc_data),
      .sc_fail_early(sc_fail_early), .sc_fail_late(sc_fail_late),
      .resv_valid(resv_valid), .resv_gran(resv_gran), .snoop_kill(snoop_kill),
      .sc_done(sc_done),
      .sc_resp_valid(sc_resp_valid), .sc_resp_fail(sc_resp_fail),
      .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
   );

   // R8
   sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_done && !lr_valid) |=> !resv_valid);
endmodule

// File: tb/sim_lrsc_resv_unit.sv
module sim_lrsc_resv_unit;
   localparam int AW = 32, DW = 64, IW = 4, SW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lr_valid = 0, snp_valid = 0, sc_valid = 0, sc_fail_early = 0, sc_fail_late = 0;
   logic [AW-1:0] lr_addr = '0, snp_addr = '0, sc_addr = '0;
   logic [IW-1:0] lr_src_id = '0, snp_id = '0;
   logic [SW-1:0] snp_size = '0;
   logic [DW-1:0] sc_data = '0;
   logic sc_resp_valid, sc_resp_fail, mem_wr_valid;
   logic [AW-1:0] mem_wr_addr;
   logic [DW-1:0] mem_wr_data;

   int checks = 0, failures = 0;
   bit m_valid = 0;
   logic [AW-1:0] m_addr = '0;
   logic [IW-1:0] m_src = '0;

   always #2 clk = ~clk;

   lrsc_resv_unit u0 (.*);

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit kills(input logic [AW-1:0] a, input int sz, input logic [IW-1:0] id);
      int lg = (sz > 3) ? sz : 3;
      return m_valid && ((a >> lg) == (m_addr >> lg)) && (id != m_src);
   endfunction

   task automatic do_lr(input logic [AW-1:0] a, input logic [IW-1:0] id);
      @(negedge clk); lr_valid = 1; lr_addr = a; lr_src_id = id;
      @(negedge clk); lr_valid = 0;
      m_valid = 1; m_addr = a; m_src = id;
   endtask

   task automatic do_snp(input logic [AW-1:0] a, input int sz, input logic [IW-1:0] id);
      logic [AW-1:0] al = (a >> sz) << sz;
      @(negedge clk); snp_valid = 1; snp_addr = al; snp_size = SW'(sz); snp_id = id;
      if (kills(al, sz, id)) m_valid = 0;
      @(negedge clk); snp_valid = 0;
   endtask

   task automatic do_sc(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit fe, input bit fl,
                        input bit sn, input logic [AW-1:0] sa, input int ssz, input logic [IW-1:0] sid,
                        input string tag);
      bit exp_ok;
      logic [AW-1:0] al = (sa >> ssz) << ssz;
      @(negedge clk); sc_valid = 1; sc_addr = a; sc_data = d; sc_fail_early = fe; sc_fail_late = fl;
      @(negedge clk); sc_valid = 0; sc_fail_early = 0; sc_fail_late = 0;
      if (fe) begin
         chk(sc_resp_valid && sc_resp_fail && !mem_wr_valid, {tag, " R6 early"},
             {sc_resp_valid, sc_resp_fail, mem_wr_valid}, 3'b110);
         m_valid = 0;
         return;
      end
      chk(!sc_resp_valid, {tag, " R2 no resp yet"}, sc_resp_valid, 0);
      if (sn) begin
         snp_valid = 1; snp_addr = al; snp_size = SW'(ssz); snp_id = sid;
         if (kills(al, ssz, sid)) m_valid = 0;
      end
      exp_ok = !fl && m_valid && ((a >> 3) == (m_addr >> 3));
      @(negedge clk); snp_valid = 0;
      chk(sc_resp_valid && (sc_resp_fail == !exp_ok) && (mem_wr_valid == exp_ok),
          {tag, " R10 resp"}, {sc_resp_valid, sc_resp_fail, mem_wr_valid}, {1'b1, !exp_ok, exp_ok});
      if (exp_ok)
         chk(mem_wr_addr == a && mem_wr_data == d, {tag, " R2 wdata"}, mem_wr_data, d);
      m_valid = 0;
   endtask

   initial begin
      #(4 * 200000);
      failures++; checks++;
      $display("FAIL watchdog");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!sc_resp_valid && !mem_wr_valid, "R1 reset outputs", {sc_resp_valid, mem_wr_valid}, 0);
      do_sc(32'h100, 64'h1, 0, 0, 0, 0, 0, 0, "R1 no lr");
      do_lr(32'h1000, 4'h3);
      do_sc(32'h1000, 64'hAA, 0, 0, 0, 0, 0, 0, "R2 basic");
      do_lr(32'h1000, 4'h3);
      do_sc(32'h1007, 64'hBB, 0, 0, 0, 0, 0, 0, "R3 same granule");
      do_lr(32'h1000, 4'h3);
      do_sc(32'h1008, 64'hCC, 0, 0, 0, 0, 0, 0, "R3 other granule");
      do_lr(32'h1010, 4'h1);
      do_snp(32'h1018, 3, 4'h2);
      do_sc(32'h1010, 64'h11, 0, 0, 0, 0, 0, 0, "R4 adjacent snoop");
      do_lr(32'h1010, 4'h1);
      do_snp(32'h1000, 6, 4'h2);
      do_sc(32'h1010, 64'h12, 0, 0, 0, 0, 0, 0, "R4 big snoop");
      do_lr(32'h1010, 4'h1);
      do_snp(32'h1012, 1, 4'h1);
      do_sc(32'h1010, 64'h13, 0, 0, 0, 0, 0, 0, "R5 source id");
      do_lr(32'h1010, 4'h1);
      do_sc(32'h1010, 64'h14, 1, 0, 0, 0, 0, 0, "R6");
      do_sc(32'h1010, 64'h15, 0, 0, 0, 0, 0, 0, "R6 after early");
      do_lr(32'h1010, 4'h1);
      do_sc(32'h1010, 64'h16, 0, 1, 0, 0, 0, 0, "R7 late");
      do_lr(32'h1020, 4'h5);
      do_sc(32'h1020, 64'h17, 0, 0, 0, 0, 0, 0, "R8 first");
      do_sc(32'h1020, 64'h18, 0, 0, 0, 0, 0, 0, "R8 second");
      do_lr(32'h1020, 4'h5);
      do_sc(32'h1020, 64'h19, 0, 0, 1, 32'h1024, 2, 4'h6, "R9 decide snoop");
      do_lr(32'h1020, 4'h5);
      do_sc(32'h1020, 64'h1A, 0, 0, 1, 32'h1040, 3, 4'h6, "R9 miss snoop");
      do_lr(32'h1020, 4'h5);
      do_lr(32'h1030, 4'h7);
      do_sc(32'h1020, 64'h1B, 0, 0, 0, 0, 0, 0, "R11 old granule");
      // R11: LR and killing snoop in one cycle
      @(negedge clk); lr_valid = 1; lr_addr = 32'h1030; lr_src_id = 4'h7;
      snp_valid = 1; snp_addr = 32'h1030; snp_size = 3; snp_id = 4'h9;
      @(negedge clk); lr_valid = 0; snp_valid = 0;
      m_valid = 1; m_addr = 32'h1030; m_src = 4'h7;
      do_sc(32'h1030, 64'h1C, 0, 0, 0, 0, 0, 0, "R11 lr wins");
      for (int i = 0; i < 400; i++) begin
         logic [AW-1:0] a = 32'h1000 + ($urandom % 4) * 8 + ($urandom % 8);
         int op = $urandom % 4;
         case (op)
            0: do_lr(a, IW'($urandom % 3));
            1: do_snp(a, $urandom % 7, IW'($urandom % 3));
            default: do_sc(a, {$urandom, $urandom}, ($urandom % 5) == 0, ($urandom % 5) == 0,
                           $urandom % 2, 32'h1000 + ($urandom % 32), $urandom % 7,
                           IW'($urandom % 3), "R4 random");
         endcase
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule